// File: doc/BRIEF.md
# Timing-State Instruction Sequencer with Hardware Interrupt Call

This block is the control sequencer of a small 16-bit accumulator machine. A 4-bit step counter is decoded into sixteen one-hot timing states. Combinational logic turns the current state, the latched opcode, the latched indirect bit and an interrupt-pending flop into register-transfer strobes for the datapath around it. Those strobes are a bus source select, load, increment and clear strobes for the address, program-counter, instruction, data, accumulator and temporary registers, memory read and write, and a clear for the interrupt-enable flag.

The datapath owns the registers themselves. The sequencer sees only the top four bits of the instruction register: the indirect flag in the most significant bit and a 3-bit opcode below it. It also sees the interrupt-enable flag and the input-ready and output-ready flags. In normal operation it runs fetch, decode, an optional indirect step and one execute sequence for load-accumulator, store-accumulator or branch. Any other opcode ends at the indirect step. When an interrupt is pending, a three-state call takes the place of the fetch. The call stores the program counter at address 0 and resumes execution at address 1.

Top module: `seq_ctrl`

## Requirements
- R1: While `rst` is high, every strobe and `bus_sel` is 0 and `t_state` shows step 0. On the first edge in reset, `int_pend` and `ind_bit` clear, so the first state after reset is a fetch step 0.
- R2: `t_state` is one-hot with bit k meaning step k. Each clock it either moves to the next step or returns to step 0. It never skips a step.
- R3: Bus source codes are 0 none, 1 AR, 2 PC, 3 DR, 4 AC, 5 IR, 6 TR and 7 memory. With `int_pend`=0, step 0 drives bus 2 with `ar_ld`. Step 1 drives bus 7 with `ir_ld`, `mem_rd` and `pc_inc`.
- R4: With `int_pend`=0, step 2 drives bus 5 with `ar_ld`. At the end of step 2, `ir_top[2:0]` is latched and shown one-hot on `d_op`, with bit k meaning opcode k, and `ir_top[3]` is latched into `ind_bit`. Both then hold until the next such step 2.
- R5: At step 3, if `d_op[7]`=0 and `ind_bit`=1, the block drives bus 7 with `mem_rd` and `ar_ld`. Otherwise step 3 drives nothing.
- R6: Opcode 2 (load) has two steps. Step 4 drives bus 7 with `mem_rd` and `dr_ld`. Step 5 asserts `ac_ld`, and the counter then returns to step 0.
- R7: Opcode 3 (store) drives bus 4 with `mem_wr` at step 4, and the counter then returns to step 0.
- R8: Opcode 4 (branch) drives bus 1 with `pc_ld` at step 4, and the counter then returns to step 0.
- R9: Opcodes 0, 1, 5, 6 and 7 end at step 3. The following state is step 0, and step 4 is never entered.
- R10: `int_pend` sets after a clock edge when `ien` is 1 and `fgi` or `fgo` is 1 while the state is step 3 or later. An edge taken while in steps 0, 1 or 2 never sets it.
- R11: With `int_pend`=1, step 0 drives bus 2 with `ar_clr` and `tr_ld`. Step 1 drives bus 6 with `mem_wr` and `pc_clr`. Step 2 asserts `pc_inc` and `ien_clr`. After step 2 the counter is at step 0, `int_pend` is 0 and `d_op` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ir_top | input | 4 | Instruction register bits: indirect flag (MSB) and opcode |
| ien | input | 1 | Interrupt enable flag |
| fgi | input | 1 | Input-ready flag |
| fgo | input | 1 | Output-ready flag |
| t_state | output | 16 | One-hot timing state |
| d_op | output | 8 | One-hot latched opcode |
| ind_bit | output | 1 | Latched indirect flag |
| int_pend | output | 1 | Interrupt call pending |
| bus_sel | output | 3 | Bus source select |
| ar_ld | output | 1 | Load AR from bus |
| ar_clr | output | 1 | Clear AR |
| pc_ld | output | 1 | Load PC from bus |
| pc_inc | output | 1 | Increment PC |
| pc_clr | output | 1 | Clear PC |
| ir_ld | output | 1 | Load IR from bus |
| dr_ld | output | 1 | Load DR from bus |
| ac_ld | output | 1 | Load AC from DR |
| tr_ld | output | 1 | Load TR from bus |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ien_clr | output | 1 | Clear interrupt enable |

## Verification
All strobes are decoded in the same cycle from registered state, so a wrong counter value shows up on `t_state` and on the strobe pattern in the very next cycle. A wrongly latched opcode or indirect bit stays hidden until step 3 or step 4. Its first symptom is a missing indirect read, a wrong execute strobe, or a return to step 0 one step early or late. A wrongly set or missed interrupt flop changes what the next step 0 does, replacing the fetch with the call or the reverse. Checks therefore walk every step of each sequence, and they also look at `int_pend` and `d_op` at the points where they must not change.

// File: rtl/seq_pkg.sv
`timescale 1ns/1ps
package seq_pkg;

    typedef enum logic [2:0] {
        BUS_NONE = 3'd0,
        BUS_AR   = 3'd1,
        BUS_PC   = 3'd2,
        BUS_DR   = 3'd3,
        BUS_AC   = 3'd4,
        BUS_IR   = 3'd5,
        BUS_TR   = 3'd6,
        BUS_MEM  = 3'd7
    } bus_src_e;

    typedef struct packed {
        logic ar_ld;
        logic ar_clr;
        logic pc_ld;
        logic pc_inc;
        logic pc_clr;
        logic ir_ld;
        logic dr_ld;
        logic ac_ld;
        logic tr_ld;
        logic mem_rd;
        logic mem_wr;
        logic ien_clr;
    } strobe_t;

    localparam int OPC_LOAD   = 2;
    localparam int OPC_STORE  = 3;
    localparam int OPC_BRANCH = 4;
    localparam int OPC_REGIO  = 7;

    // Highest step index the strobe decoder looks at
    localparam int LAST_STEP = 5;

endpackage

// File: rtl/seq_timer.sv
`timescale 1ns/1ps
module seq_timer #(
    parameter int CNT_W = 4,
    localparam int STATES = 1 << CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    output logic [STATES-1:0] t_onehot
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } timer_t;

    timer_t tm_d, tm_q;

    always_comb begin
        tm_d = tm_q;
        if (clr) begin
            tm_d.cnt = '0;
        end else begin
            tm_d.cnt = tm_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tm_q <= '0;
        end else begin
            tm_q <= tm_d;
        end
    end

    for (genvar k = 0; k < STATES; k++) begin : g_dec
        assign t_onehot[k] = (tm_q.cnt == CNT_W'(k));
    end

    AST_STEP_OR_HOME: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (tm_q.cnt == CNT_W'($past(tm_q.cnt) + 1'b1)) || (tm_q.cnt == '0)); // R2

    AST_CLEAR_HOME: assert property (@(posedge clk) disable iff (rst)
        clr |=> t_onehot[0]); // R2

endmodule

// File: rtl/seq_opdecode.sv
`timescale 1ns/1ps
module seq_opdecode #(
    parameter int OP_W = 3,
    localparam int DEC_W = 1 << OP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic [OP_W:0]    ir_top,
    output logic [DEC_W-1:0] d_onehot,
    output logic             ind_q
);

    typedef struct packed {
        logic            ind;
        logic [OP_W-1:0] op;
    } dec_t;

    dec_t dec_d, dec_q;

    always_comb begin
        dec_d = dec_q;
        if (capture) begin
            dec_d.ind = ir_top[OP_W];
            dec_d.op  = ir_top[OP_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    for (genvar k = 0; k < DEC_W; k++) begin : g_dec
        assign d_onehot[k] = (dec_q.op == OP_W'(k));
    end

    assign ind_q = dec_q.ind;

    AST_DEC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(d_onehot) && $stable(ind_q)); // R4

endmodule

// File: rtl/seq_intr.sv
`timescale 1ns/1ps
module seq_intr (
    input  logic clk,
    input  logic rst,
    input  logic ien,
    input  logic fgi,
    input  logic fgo,
    input  logic early,
    input  logic done,
    output logic r_q
);

    typedef struct packed {
        logic pend;
    } intr_t;

    intr_t ir_d, ir_q;

    always_comb begin
        ir_d = ir_q;
        if (done) begin
            ir_d.pend = 1'b0;
        end else if (!early && ien && (fgi || fgo)) begin
            ir_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ir_q <= '0;
        end else begin
            ir_q <= ir_d;
        end
    end

    assign r_q = ir_q.pend;

    AST_NO_EARLY_SET: assert property (@(posedge clk) disable iff (rst)
        (early && !r_q) |=> !r_q); // R10

    AST_SET_LATE: assert property (@(posedge clk) disable iff (rst)
        (!early && ien && (fgi || fgo)) |=> r_q); // R10

endmodule

// File: rtl/seq_strobe.sv
`timescale 1ns/1ps
module seq_strobe
    import seq_pkg::*;
#(
    parameter int OP_W = 3,
    localparam int DEC_W = 1 << OP_W
) (
    input  logic                 rst,
    input  logic [LAST_STEP:0]   t,
    input  logic [DEC_W-1:0]     d,
    input  logic                 ind,
    input  logic                 r,
    output bus_src_e             bus,
    output strobe_t              s,
    output logic                 sc_clr,
    output logic                 capture,
    output logic                 int_done
);

    logic mem_ref;
    logic do_load;
    logic do_store;
    logic do_branch;
    logic out_of_scope;

    always_comb begin
        mem_ref      = !d[OPC_REGIO];
        do_load      = d[OPC_LOAD];
        do_store     = d[OPC_STORE];
        do_branch    = d[OPC_BRANCH];
        out_of_scope = d[0] | d[1] | d[5] | d[6] | d[OPC_REGIO];
    end

    always_comb begin
        s        = '0;
        bus      = BUS_NONE;
        sc_clr   = 1'b0;
        capture  = 1'b0;
        int_done = 1'b0;

        if (r) begin
            // hardware call: save PC at 0, resume at 1
            if (t[0]) begin
                bus      = BUS_PC;
                s.ar_clr = 1'b1;
                s.tr_ld  = 1'b1;
            end
            if (t[1]) begin
                bus      = BUS_TR;
                s.mem_wr = 1'b1;
                s.pc_clr = 1'b1;
            end
            if (t[2]) begin
                s.pc_inc  = 1'b1;
                s.ien_clr = 1'b1;
                sc_clr    = 1'b1;
                int_done  = 1'b1;
            end
        end else begin
            if (t[0]) begin
                bus     = BUS_PC;
                s.ar_ld = 1'b1;
            end
            if (t[1]) begin
                bus      = BUS_MEM;
                s.ir_ld  = 1'b1;
                s.mem_rd = 1'b1;
                s.pc_inc = 1'b1;
            end
            if (t[2]) begin
                bus     = BUS_IR;
                s.ar_ld = 1'b1;
                capture = 1'b1;
            end
        end

        // execute-side steps do not depend on the pending call
        if (t[3]) begin
            if (mem_ref && ind) begin
                bus      = BUS_MEM;
                s.mem_rd = 1'b1;
                s.ar_ld  = 1'b1;
            end
            if (out_of_scope) begin
                sc_clr = 1'b1;
            end
        end

        if (t[4]) begin
            if (do_load) begin
                bus      = BUS_MEM;
                s.mem_rd = 1'b1;
                s.dr_ld  = 1'b1;
            end
            if (do_store) begin
                bus      = BUS_AC;
                s.mem_wr = 1'b1;
                sc_clr   = 1'b1;
            end
            if (do_branch) begin
                bus     = BUS_AR;
                s.pc_ld = 1'b1;
                sc_clr  = 1'b1;
            end
        end

        if (t[5] && do_load) begin
            s.ac_ld = 1'b1;
            sc_clr  = 1'b1;
        end

        if (rst) begin
            s   = '0;
            bus = BUS_NONE;
        end
    end

endmodule

// File: rtl/seq_ctrl.sv
`timescale 1ns/1ps
module seq_ctrl
    import seq_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int OP_W  = 3,
    localparam int STATES = 1 << CNT_W,
    localparam int DEC_W  = 1 << OP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W:0]     ir_top,
    input  logic              ien,
    input  logic              fgi,
    input  logic              fgo,
    output logic [STATES-1:0] t_state,
    output logic [DEC_W-1:0]  d_op,
    output logic              ind_bit,
    output logic              int_pend,
    output logic [2:0]        bus_sel,
    output logic              ar_ld,
    output logic              ar_clr,
    output logic              pc_ld,
    output logic              pc_inc,
    output logic              pc_clr,
    output logic              ir_ld,
    output logic              dr_ld,
    output logic              ac_ld,
    output logic              tr_ld,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              ien_clr
);

    logic     sc_clr;
    logic     capture;
    logic     int_done;
    logic     early;
    bus_src_e bus;
    strobe_t  stb;

    seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .clr      (sc_clr),
        .t_onehot (t_state)
    );

    seq_opdecode #(.OP_W(OP_W)) u_dec (
        .clk      (clk),
        .rst      (rst),
        .capture  (capture),
        .ir_top   (ir_top),
        .d_onehot (d_op),
        .ind_q    (ind_bit)
    );

    assign early = t_state[0] | t_state[1] | t_state[2];

    seq_intr u_intr (
        .clk   (clk),
        .rst   (rst),
        .ien   (ien),
        .fgi   (fgi),
        .fgo   (fgo),
        .early (early),
        .done  (int_done),
        .r_q   (int_pend)
    );

    seq_strobe #(.OP_W(OP_W)) u_stb (
        .rst      (rst),
        .t        (t_state[LAST_STEP:0]),
        .d        (d_op),
        .ind      (ind_bit),
        .r        (int_pend),
        .bus      (bus),
        .s        (stb),
        .sc_clr   (sc_clr),
        .capture  (capture),
        .int_done (int_done)
    );

    assign bus_sel = bus;
    assign ar_ld   = stb.ar_ld;
    assign ar_clr  = stb.ar_clr;
    assign pc_ld   = stb.pc_ld;
    assign pc_inc  = stb.pc_inc;
    assign pc_clr  = stb.pc_clr;
    assign ir_ld   = stb.ir_ld;
    assign dr_ld   = stb.dr_ld;
    assign ac_ld   = stb.ac_ld;
    assign tr_ld   = stb.tr_ld;
    assign mem_rd  = stb.mem_rd;
    assign mem_wr  = stb.mem_wr;
    assign ien_clr = stb.ien_clr;

    AST_QUIET_IN_RESET: assert property (@(posedge clk)
        rst |-> (bus_sel == 3'd0) && (stb == '0)); // R1

    AST_RW_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr)); // R3

    AST_CALL_RETURNS: assert property (@(posedge clk) disable iff (rst)
        (int_pend && t_state[2]) |=> (t_state[0] && !int_pend && $stable(d_op))); // R11

    AST_NO_STEP4_OTHER: assert property (@(posedge clk) disable iff (rst)
        (t_state[3] && !(d_op[2] || d_op[3] || d_op[4])) |=> t_state[0]); // R9

endmodule

// File: tb/seq_ctrl_test.sv
`timescale 1ns/1ps
module seq_ctrl_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  ir_top;
    logic        ien, fgi, fgo;
    logic [15:0] t_state;
    logic [7:0]  d_op;
    logic        ind_bit, int_pend;
    logic [2:0]  bus_sel;
    logic ar_ld, ar_clr, pc_ld, pc_inc, pc_clr, ir_ld, dr_ld, ac_ld, tr_ld;
    logic mem_rd, mem_wr, ien_clr;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    localparam logic [11:0] F_ARLD  = 12'h800;
    localparam logic [11:0] F_ARCLR = 12'h400;
    localparam logic [11:0] F_PCLD  = 12'h200;
    localparam logic [11:0] F_PCINC = 12'h100;
    localparam logic [11:0] F_PCCLR = 12'h080;
    localparam logic [11:0] F_IRLD  = 12'h040;
    localparam logic [11:0] F_DRLD  = 12'h020;
    localparam logic [11:0] F_ACLD  = 12'h010;
    localparam logic [11:0] F_TRLD  = 12'h008;
    localparam logic [11:0] F_MRD   = 12'h004;
    localparam logic [11:0] F_MWR   = 12'h002;
    localparam logic [11:0] F_IENCL = 12'h001;

    always #2 clk = ~clk;

    seq_ctrl uut (
        .clk(clk), .rst(rst), .ir_top(ir_top), .ien(ien), .fgi(fgi), .fgo(fgo),
        .t_state(t_state), .d_op(d_op), .ind_bit(ind_bit), .int_pend(int_pend),
        .bus_sel(bus_sel), .ar_ld(ar_ld), .ar_clr(ar_clr), .pc_ld(pc_ld),
        .pc_inc(pc_inc), .pc_clr(pc_clr), .ir_ld(ir_ld), .dr_ld(dr_ld),
        .ac_ld(ac_ld), .tr_ld(tr_ld), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .ien_clr(ien_clr)
    );

    function automatic logic [14:0] obs();
        return {bus_sel, ar_ld, ar_clr, pc_ld, pc_inc, pc_clr, ir_ld,
                dr_ld, ac_ld, tr_ld, mem_rd, mem_wr, ien_clr};
    endfunction

    function automatic logic [14:0] w(input logic [2:0] b, input logic [11:0] f);
        return {b, f};
    endfunction

    task automatic chk_val(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_step(input string tag, input int step, input logic [14:0] exp_w);
        chk_val({tag, " state"}, t_state, 16'(1 << step));
        chk_val({tag, " strobes"}, 16'(obs()), 16'(exp_w));
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // fetch and decode; leaves the bench at step 3
    task automatic do_fetch(input string tag, input logic [3:0] ir);
        chk_step({tag, " R3 T0"}, 0, w(3'd2, F_ARLD));
        tick();
        chk_step({tag, " R3 T1"}, 1, w(3'd7, F_IRLD | F_MRD | F_PCINC));
        ir_top = ir;
        tick();
        chk_step({tag, " R4 T2"}, 2, w(3'd5, F_ARLD));
        tick();
        chk_val({tag, " R4 d_op"}, 16'(d_op), 16'(1 << ir[2:0]));
        chk_val({tag, " R4 ind"}, 16'(ind_bit), 16'(ir[3]));
    endtask

    task automatic t_reset();
        rst = 1'b1; ir_top = 4'h0; ien = 1'b0; fgi = 1'b0; fgo = 1'b0;
        repeat (3) tick();
        chk_val("R1 reset state", t_state, 16'h0001);
        chk_val("R1 reset strobes", 16'(obs()), 16'h0000);
        chk_val("R1 reset pend", 16'(int_pend), 16'h0);
        chk_val("R1 reset ind", 16'(ind_bit), 16'h0);
        rst = 1'b0;
        #1;
        chk_step("R1 first fetch", 0, w(3'd2, F_ARLD));
    endtask

    task automatic t_load(input logic ind);
        do_fetch("R6 load", {ind, 3'd2});
        chk_step("R5 load T3", 3, ind ? w(3'd7, F_MRD | F_ARLD) : 15'h0);
        tick();
        chk_step("R6 load T4", 4, w(3'd7, F_MRD | F_DRLD));
        chk_val("R4 hold T4", 16'(d_op), 16'h0004);
        tick();
        chk_step("R6 load T5", 5, w(3'd0, F_ACLD));
        tick();
        chk_val("R6 load home", t_state, 16'h0001);
    endtask

    task automatic t_store();
        do_fetch("R7 store", 4'h3);
        chk_step("R5 store T3", 3, 15'h0);
        tick();
        chk_step("R7 store T4", 4, w(3'd4, F_MWR));
        tick();
        chk_val("R7 store home", t_state, 16'h0001);
    endtask

    task automatic t_branch();
        do_fetch("R8 branch", 4'h4);
        tick();
        chk_step("R8 branch T4", 4, w(3'd1, F_PCLD));
        chk_val("R10 no pend ien off", 16'(int_pend), 16'h0);
        tick();
        chk_val("R8 branch home", t_state, 16'h0001);
    endtask

    task automatic t_other(input logic [3:0] ir);
        do_fetch("R9 other", ir);
        chk_step("R5 other T3", 3,
                 (ir[3] && ir[2:0] != 3'd7) ? w(3'd7, F_MRD | F_ARLD) : 15'h0);
        tick();
        chk_val("R9 other home", t_state, 16'h0001);
    endtask

    task automatic t_intr(input logic use_out);
        ien = 1'b1;
        fgi = !use_out;
        fgo = use_out;
        do_fetch("R10 intr", 4'h3);
        chk_val("R10 no set early", 16'(int_pend), 16'h0);
        tick();
        chk_val("R10 set late", 16'(int_pend), 16'h1);
        chk_step("R7 store under pend", 4, w(3'd4, F_MWR));
        tick();
        chk_step("R11 call T0", 0, w(3'd2, F_ARCLR | F_TRLD));
        ir_top = 4'hE;
        tick();
        chk_step("R11 call T1", 1, w(3'd6, F_MWR | F_PCCLR));
        tick();
        chk_step("R11 call T2", 2, w(3'd0, F_PCINC | F_IENCL));
        ien = 1'b0; fgi = 1'b0; fgo = 1'b0;
        tick();
        chk_val("R11 call home", t_state, 16'h0001);
        chk_val("R11 pend cleared", 16'(int_pend), 16'h0);
        chk_val("R11 d_op kept", 16'(d_op), 16'h0008);
    endtask

    task automatic t_reset_mid();
        ien = 1'b1; fgi = 1'b1;
        do_fetch("R1 mid", 4'hA);
        tick();
        chk_val("R10 pend before reset", 16'(int_pend), 16'h1);
        rst = 1'b1; ien = 1'b0; fgi = 1'b0;
        tick();
        chk_val("R1 mid state", t_state, 16'h0001);
        chk_val("R1 mid strobes", 16'(obs()), 16'h0000);
        chk_val("R1 mid pend", 16'(int_pend), 16'h0);
        chk_val("R1 mid ind", 16'(ind_bit), 16'h0);
        rst = 1'b0;
        #1;
        chk_step("R1 mid fetch", 0, w(3'd2, F_ARLD));
    endtask

    initial begin
        t_reset();
        t_load(1'b0);
        t_load(1'b1);
        t_store();
        t_branch();
        t_other(4'hF);
        t_other(4'h9);
        t_other(4'h5);
        t_intr(1'b0);
        t_intr(1'b1);
        fgi = 1'b1;
        t_branch();
        fgi = 1'b0;
        t_reset_mid();
        t_load(1'b0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule